// File: doc/BRIEF.md
# Two-Slot Overwriting Signal Mailbox

This block moves single data items from a producer to a consumer that keep no common timing. The producer is never made to wait: every write is accepted at once, and a write that finds an unread item replaces it. The consumer waits until an unread item exists, takes it once, and after that waits again. Storage is two registered slots. At any moment the producer owns one slot and the consumer owns the other, so neither side ever touches the slot the other side is using.

Slot steering uses two flags. Each flag is owned by one side and only read by the other, and each one reaches the far side through a two-stage synchroniser. The producer publishes the slot it is writing. The consumer publishes the slot it wants next, together with a bit that says it is waiting for that slot. The producer gives up its slot only after it has written that slot, and only when the consumer is waiting for it. The consumer then moves to the other slot. Because of this, a read that starts after the producer has settled returns the most recent item. Each side uses a four-phase request/acknowledge handshake.

Top module: `sigbox_mailbox`

## Requirements
- R1: After reset, wr_ack and rd_ack are low and the mailbox holds no unread item.
- R2: wr_ack rises one clock after wr_req is sampled high and falls one clock after wr_req is sampled low, whatever the consumer is doing.
- R3: rd_ack never rises while no unread item exists. A read request held while the mailbox is empty is answered after the next write completes, and it returns that write's data.
- R4: A read requested after the producer has finished a burst of writes returns the last value of that burst.
- R5: An item is delivered at most once. A new read request with no write since the previous read stays unanswered until a write completes.
- R6: rd_data does not change while rd_ack is high, even when writes complete during the read.
- R7: The producer never stores into the slot the consumer is currently reading.
- R8: When writes complete during a read, the next read returns the last of those writes.
- R9: rd_ack rises only while rd_req is high, and it falls one clock after rd_req is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_req | input | 1 | Producer request, four-phase |
| wr_data | input | DATA_W | Item to store, sampled with the request |
| wr_ack | output | 1 | Producer acknowledge |
| rd_req | input | 1 | Consumer request, four-phase |
| rd_ack | output | 1 | Consumer acknowledge; rd_data is valid while it is high |
| rd_data | output | DATA_W | Item delivered to the consumer |

## Verification
The assertions check on every cycle the rules that hold locally in time. These are: the slot exclusion between a store and an active read, a stable rd_data for as long as rd_ack is high, the acknowledge timing on both sides, and the rule that every rising rd_ack has at least one completed store behind it since the previous one. Other properties depend on the order of whole transactions, and only the bench scenarios can show them. Such properties include which value a read returns after a burst, a burst during a read, or a blocked request, and whether a second request without a new write really stays unanswered.

// File: rtl/sigbox_pkg.sv
package sigbox_pkg;
    localparam int SLOT_CNT = 2;

    typedef logic slot_t;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_ACK  = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_HOLD = 1'b1
    } rd_state_e;

    typedef struct packed {
        wr_state_e st;
        slot_t     slot;
        logic      dirty;
        logic      ack;
    } wr_regs_t;

    typedef struct packed {
        rd_state_e st;
        slot_t     slot;
        logic      waiting;
        logic      ack;
    } rd_regs_t;
endpackage

// File: rtl/sigbox_sync.sv
module sigbox_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic [W-1:0] stage_d;
            if (i == 0) begin : g_first
                always_comb stage_d = d;
            end else begin : g_next
                always_comb stage_d = stage_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= stage_d;
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sigbox_writer.sv
module sigbox_writer
    import sigbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_req,
    output logic  wr_ack,
    input  logic  rd_wait_s,
    input  slot_t rd_slot_s,
    output logic  store_en,
    output slot_t store_slot,
    output slot_t wr_slot
);
    wr_regs_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        store_en = 1'b0;
        case (w_q.st)
            W_IDLE: if (wr_req) begin
                store_en = 1'b1;
                w_d.dirty = 1'b1;
                w_d.st    = W_ACK;
                w_d.ack   = 1'b1;
            end
            W_ACK: if (!wr_req) begin
                w_d.st  = W_IDLE;
                w_d.ack = 1'b0;
            end
            default: w_d = w_q;
        endcase
        // hand the freshly written slot over when the reader waits for it
        if (!store_en && w_q.dirty && rd_wait_s && (rd_slot_s == w_q.slot)) begin
            w_d.slot  = ~w_q.slot;
            w_d.dirty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: W_IDLE, slot: 1'b1, dirty: 1'b0, ack: 1'b0};
        else        w_q <= w_d;
    end

    assign wr_ack     = w_q.ack;
    assign store_slot = w_q.slot;
    assign wr_slot    = w_q.slot;
endmodule

// File: rtl/sigbox_reader.sv
module sigbox_reader
    import sigbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_req,
    output logic  rd_ack,
    input  slot_t wr_slot_s,
    output slot_t rd_slot,
    output logic  rd_wait,
    output logic  rd_busy
);
    rd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            R_IDLE: begin
                r_d.waiting = 1'b0;
                if (rd_req) begin
                    if (wr_slot_s != r_q.slot) begin
                        r_d.st  = R_HOLD;
                        r_d.ack = 1'b1;
                    end else begin
                        r_d.waiting = 1'b1;
                    end
                end
            end
            R_HOLD: if (!rd_req) begin
                r_d.st   = R_IDLE;
                r_d.ack  = 1'b0;
                r_d.slot = ~r_q.slot;
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: R_IDLE, slot: 1'b1, waiting: 1'b0, ack: 1'b0};
        else        r_q <= r_d;
    end

    assign rd_ack  = r_q.ack;
    assign rd_slot = r_q.slot;
    assign rd_wait = r_q.waiting;
    assign rd_busy = (r_q.st == R_HOLD);
endmodule

// File: rtl/sigbox_slots.sv
module sigbox_slots
    import sigbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en,
    input  slot_t             store_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  slot_t             rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [SLOT_CNT];

    generate
        for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
            logic [DATA_W-1:0] slot_d;
            always_comb begin
                slot_d = slot_q[i];
                if (store_en && (int'(store_slot) == i)) slot_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q[i] <= '0;
                else        slot_q[i] <= slot_d;
            end
        end
    endgenerate

    assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/sigbox_mailbox.sv
module sigbox_mailbox
    import sigbox_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data
);
    logic  w_store;
    slot_t w_store_slot;
    slot_t w_slot;
    slot_t w_slot_s;
    slot_t r_slot;
    logic  r_wait;
    logic  r_busy;
    logic [1:0] r_flags_s;

    sigbox_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_w2r (
        .clk(clk), .rst_n(rst_n), .d(w_slot), .q(w_slot_s)
    );

    sigbox_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_r2w (
        .clk(clk), .rst_n(rst_n), .d({r_wait, r_slot}), .q(r_flags_s)
    );

    sigbox_writer u_wr (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ack(wr_ack),
        .rd_wait_s(r_flags_s[1]), .rd_slot_s(r_flags_s[0]),
        .store_en(w_store), .store_slot(w_store_slot), .wr_slot(w_slot)
    );

    sigbox_reader u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
        .wr_slot_s(w_slot_s), .rd_slot(r_slot), .rd_wait(r_wait), .rd_busy(r_busy)
    );

    sigbox_slots #(.DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .store_en(w_store), .store_slot(w_store_slot),
        .wr_data(wr_data), .rd_slot(r_slot), .rd_data(rd_data)
    );
endmodule

// File: rtl/sigbox_mailbox_chk.sv
module sigbox_mailbox_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic              wr_ack,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              w_store,
    input logic              w_store_slot,
    input logic              r_busy,
    input logic              r_slot
);
    logic fresh_q, ack_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q    <= 1'b0;
            ack_prev_q <= 1'b0;
        end else begin
            ack_prev_q <= rd_ack;
            if (w_store)                   fresh_q <= 1'b1;
            else if (rd_ack && !ack_prev_q) fresh_q <= 1'b0;
        end
    end

    // R2
    wr_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_ack);
    // R2
    wr_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && wr_ack) |=> !wr_ack);
    // R3
    rd_needs_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !ack_prev_q) |-> fresh_q);
    // R6
    rd_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && $past(rd_ack)) |-> (rd_data == $past(rd_data)));
    // R7
    slot_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_store && r_busy) |-> (w_store_slot != r_slot));
    // R9
    rd_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ack) |-> $past(rd_req));
    // R9
    rd_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && rd_ack) |=> !rd_ack);
endmodule

bind sigbox_mailbox sigbox_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .w_store(w_store), .w_store_slot(w_store_slot),
    .r_busy(r_busy), .r_slot(r_slot)
);

// File: tb/sigbox_mailbox_tb.sv
module sigbox_mailbox_tb;
    localparam int DW = 8;
    localparam int RD_TIMEOUT = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ack;
    logic          rd_req = 1'b0;
    logic          rd_ack;
    logic [DW-1:0] rd_data;

    int tests = 0;
    int failed = 0;
    int cycles = 0;
    bit done = 1'b0;

    sigbox_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .wr_ack(wr_ack), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failed++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [DW-1:0] v);
        @(negedge clk);
        wr_data = v;
        wr_req  = 1'b1;
        @(negedge clk);
        chk(wr_ack == 1'b1, "R2 ack rise", int'(wr_ack), 1);
        wr_req = 1'b0;
        @(negedge clk);
        chk(wr_ack == 1'b0, "R2 ack fall", int'(wr_ack), 0);
    endtask

    task automatic wait_rd_ack();
        for (int k = 0; k < RD_TIMEOUT && !rd_ack; k++) @(negedge clk);
    endtask

    task automatic finish_read();
        rd_req = 1'b0;
        @(negedge clk);
        chk(rd_ack == 1'b0, "R9 ack fall", int'(rd_ack), 0);
    endtask

    task automatic do_read(input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        wait_rd_ack();
        chk(rd_ack == 1'b1, {req, " ack"}, int'(rd_ack), 1);
        chk(rd_data == exp, req, int'(rd_data), int'(exp));
        finish_read();
    endtask

    task automatic expect_blocked(input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rd_ack) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(wr_ack == 1'b0 && rd_ack == 1'b0, "R1 acks low", int'({wr_ack, rd_ack}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3: empty mailbox blocks the reader
        rd_req = 1'b1;
        expect_blocked(30, "R3 empty after reset (R1)");
        // R3: held request answered by next write; writer still never waits (R2)
        do_write(8'h5A);
        wait_rd_ack();
        chk(rd_ack == 1'b1, "R3 answered after write", int'(rd_ack), 1);
        chk(rd_data == 8'h5A, "R3 data", int'(rd_data), 8'h5A);
        finish_read();

        // R5: no new write, so the next request stays unanswered
        @(negedge clk);
        rd_req = 1'b1;
        expect_blocked(30, "R5 no second delivery");
        do_write(8'h77);
        wait_rd_ack();
        chk(rd_data == 8'h77, "R5 new item after block", int'(rd_data), 8'h77);
        finish_read();

        // R4: sweep burst length and idle gap; expect the last write
        for (int n = 1; n <= 5; n++) begin
            for (int gap = 0; gap <= 8; gap += 4) begin
                logic [DW-1:0] last;
                last = '0;
                for (int i = 0; i < n; i++) begin
                    last = DW'(8'h10 * n + i + gap);
                    do_write(last);
                end
                repeat (gap) @(negedge clk);
                do_read(last, "R4 newest of burst");
            end
        end

        // R6/R7/R8: writes completing during a read
        for (int m = 1; m <= 3; m++) begin
            logic [DW-1:0] held;
            logic [DW-1:0] last;
            held = DW'(8'hA0 + m);
            last = held;
            do_write(held);
            @(negedge clk);
            rd_req = 1'b1;
            wait_rd_ack();
            chk(rd_data == held, "R4 data before in-read writes", int'(rd_data), int'(held));
            for (int i = 0; i < m; i++) begin
                last = DW'(8'hC0 + 8'h10 * m + i);
                do_write(last);
                chk(rd_ack == 1'b1 && rd_data == held, "R6 R7 data held during write",
                    int'(rd_data), int'(held));
            end
            finish_read();
            do_read(last, "R8 last write during read");
        end

        // R9: ack never rises without a request, even with an item waiting
        do_write(8'h3C);
        expect_blocked(20, "R9 no request no ack");
        do_read(8'h3C, "R9 later read");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule